// File: doc/BRIEF.md
# DDR SDRAM Bank Timing Guard

This block sits between the command generator of a memory controller and the command bus of one DDR SDRAM rank. It keeps, for every bank, whether a row is open and which one. It also keeps the cycle distances since the events that the device's minimum spacings count from: the bank's last activate, its last column access and its last close. For the whole rank it counts from the last activate, the last column access, the last refresh and the last mode register load. For the command presented on its inputs it drives a combinational legal flag, which is high only when every spacing that applies is met.

The controller shows a candidate command and reads the flag. It then raises `cmd_valid` to issue the command in that cycle. A legal issued command updates the bank state at the next clock edge. An illegal issued command leaves all state untouched and raises a one-cycle error pulse. Address bit 10 selects the scope of a precharge. On a read or write, the same bit requests auto-precharge: the guard then closes the bank by itself once the burst and any write recovery have passed, and the row-precharge timer starts counting from that point. Every timing value is a parameter in clock cycles.

Top module: `ddr_bank_guard`

## Requirements
- R1: After reset every bank is closed, `cmd_error` is low, and an activate to any bank is legal in the first cycle.
- R2: `cmd_op` encodes NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4, REFRESH=5, MODE-LOAD=6. NOP is always legal, and code 7 is never legal.
- R3: An activate is legal only if the addressed bank is closed, at least T_RP cycles have passed since that bank closed, at least T_RC cycles have passed since that bank's last activate, and at least T_RRD cycles have passed since an activate to any bank.
- R4: A read or write is legal only if the bank is open with no auto-precharge pending and at least T_RCD cycles have passed since its activate. Any two column commands must be at least BURST_LEN/2 cycles apart. A read after a write must wait BURST_LEN/2+T_WTR cycles.
- R5: A precharge with address bit 10 low is legal only if the addressed bank is open with no auto-precharge pending, at least T_RAS cycles have passed since its activate, and at least BURST_LEN/2 cycles (after a read) or BURST_LEN/2+T_WR cycles (after a write) have passed since its last column command.
- R6: A precharge with address bit 10 high is legal when every open bank satisfies the R5 conditions, and it closes every open bank.
- R7: A read or write with address bit 10 high closes its bank, without a further command, in the first cycle in which the R5 recovery and T_RAS are both met. T_RP counts from that cycle.
- R8: A refresh is legal only when every bank is closed and at least T_RP cycles have passed since each bank closed. After a refresh, no command other than NOP is legal for T_RFC cycles.
- R9: A mode load has the same idle condition as a refresh. After it, no command other than NOP is legal for T_MRD cycles.
- R10: An issued command that is not legal changes no bank state and raises `cmd_error` for exactly the following cycle.
- R11: `bank_open` shows each bank's open state. `row_hit` is high when the addressed bank is open with no auto-precharge pending and its row equals `cmd_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Issue the presented command this cycle |
| cmd_op | input | 3 | Command code (R2) |
| cmd_bank | input | BA_W (2) | Bank address |
| cmd_addr | input | ROW_W (13) | Row on activate. Bit 10 selects precharge scope or auto-precharge |
| cmd_legal | output | 1 | Presented command meets every rule |
| cmd_error | output | 1 | Registered pulse after an illegal issue |
| bank_open | output | NB (4) | Per-bank open flags |
| row_hit | output | 1 | Addressed bank holds `cmd_addr` as its open row |

## Verification
The hardest case to reach is an auto-precharge close in which write recovery and T_RAS both decide the close cycle while other banks and the rank-wide column spacing are also active. Random commands almost never line these up. A directed sequence therefore activates two banks T_RRD apart, writes to one of them, and reads with auto-precharge from the other. It then probes the precharge and activate flags in the exact cycles one before and at each limit. Constrained random traffic, which mostly issues legal commands and sometimes illegal ones, then runs against a bench model that works from event timestamps.

// File: rtl/bank_guard_pkg.sv
package bank_guard_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4,
    OP_REF = 3'd5,
    OP_MRS = 3'd6
  } guard_op_e;
endpackage

// File: rtl/elapsed_ctr.sv
// Counts cycles since the last start pulse; saturates at all-ones (reset value).
module elapsed_ctr #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] SAT = '1;

  always_ff @(posedge clk) begin
    if (rst)               count <= SAT;
    else if (start)        count <= W'(1);
    else if (count != SAT) count <= count + W'(1);
  end
endmodule

// File: rtl/bank_tracker.sv
module bank_tracker #(
  parameter int CW      = 6,
  parameter int ROW_W   = 13,
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int T_RAS   = 7,
  parameter int T_RC    = 10,
  parameter int T_WR    = 3,
  parameter int HALF_BL = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_i,
  input  logic             col_i,
  input  logic             col_wr_i,
  input  logic             col_ap_i,
  input  logic             pre_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             busy_o,
  output logic             can_act_o,
  output logic             can_col_o,
  output logic             can_pre_o,
  output logic             idle_o
);
  localparam logic [CW-1:0] RD_REC = CW'(HALF_BL);
  localparam logic [CW-1:0] WR_REC = CW'(HALF_BL + T_WR);

  logic             open_q, ap_q, last_wr_q;
  logic [ROW_W-1:0] row_q;
  logic [CW-1:0]    act_cnt, rw_cnt, cls_cnt;
  logic             rec_ok, ras_ok, ap_fire, close_ev;

  elapsed_ctr #(.W(CW)) act_ctr_i (.clk(clk), .rst(rst), .start(act_i),    .count(act_cnt));
  elapsed_ctr #(.W(CW)) rw_ctr_i  (.clk(clk), .rst(rst), .start(col_i),    .count(rw_cnt));
  elapsed_ctr #(.W(CW)) cls_ctr_i (.clk(clk), .rst(rst), .start(close_ev), .count(cls_cnt));

  always_comb begin
    rec_ok    = rw_cnt >= (last_wr_q ? WR_REC : RD_REC);
    ras_ok    = act_cnt >= CW'(T_RAS);
    ap_fire   = open_q && ap_q && rec_ok && ras_ok;
    close_ev  = pre_i || ap_fire;
    can_act_o = !open_q && (cls_cnt >= CW'(T_RP)) && (act_cnt >= CW'(T_RC));
    can_col_o = open_q && !ap_q && (act_cnt >= CW'(T_RCD));
    can_pre_o = open_q && !ap_q && ras_ok && rec_ok;
    idle_o    = !open_q && (cls_cnt >= CW'(T_RP));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q    <= 1'b0;
      ap_q      <= 1'b0;
      last_wr_q <= 1'b0;
      row_q     <= '0;
    end else begin
      if (act_i) begin
        open_q <= 1'b1;
        row_q  <= row_i;
      end
      if (col_i) begin
        last_wr_q <= col_wr_i;
        ap_q      <= col_ap_i;
      end
      if (close_ev) begin
        open_q <= 1'b0;
        ap_q   <= 1'b0;
      end
    end
  end

  assign open_o = open_q;
  assign row_o  = row_q;
  assign busy_o = ap_q;

  // R3
  act_closed_chk: assert property (@(posedge clk) disable iff (rst) act_i |-> !open_q);
  // R4
  col_open_chk: assert property (@(posedge clk) disable iff (rst)
    col_i |-> (open_q && !ap_q && act_cnt >= CW'(T_RCD)));
  // R5
  pre_ras_chk: assert property (@(posedge clk) disable iff (rst) pre_i |-> act_cnt >= CW'(T_RAS));
  // R7
  close_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(open_q) |-> $past(pre_i || ap_q));
endmodule

// File: rtl/rank_spacing.sv
module rank_spacing #(
  parameter int CW      = 6,
  parameter int T_RRD   = 2,
  parameter int T_MRD   = 2,
  parameter int T_RFC   = 12,
  parameter int T_WTR   = 1,
  parameter int HALF_BL = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic act_ev,
  input  logic col_ev,
  input  logic col_wr,
  input  logic ref_ev,
  input  logic mrs_ev,
  output logic rrd_ok,
  output logic rd_ok,
  output logic wr_ok,
  output logic quiet_ok
);
  logic [CW-1:0] rrd_cnt, col_cnt, ref_cnt, mrs_cnt;
  logic          last_wr_q;

  elapsed_ctr #(.W(CW)) rrd_ctr_i (.clk(clk), .rst(rst), .start(act_ev), .count(rrd_cnt));
  elapsed_ctr #(.W(CW)) col_ctr_i (.clk(clk), .rst(rst), .start(col_ev), .count(col_cnt));
  elapsed_ctr #(.W(CW)) ref_ctr_i (.clk(clk), .rst(rst), .start(ref_ev), .count(ref_cnt));
  elapsed_ctr #(.W(CW)) mrs_ctr_i (.clk(clk), .rst(rst), .start(mrs_ev), .count(mrs_cnt));

  always_ff @(posedge clk) begin
    if (rst)         last_wr_q <= 1'b0;
    else if (col_ev) last_wr_q <= col_wr;
  end

  always_comb begin
    rrd_ok   = rrd_cnt >= CW'(T_RRD);
    wr_ok    = col_cnt >= CW'(HALF_BL);
    rd_ok    = col_cnt >= (last_wr_q ? CW'(HALF_BL + T_WTR) : CW'(HALF_BL));
    quiet_ok = (ref_cnt >= CW'(T_RFC)) && (mrs_cnt >= CW'(T_MRD));
  end

  generate
    if (T_MRD > 1) begin : g_mrd_chk
      // R9
      mrd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        mrs_ev |=> !(act_ev || col_ev || ref_ev || mrs_ev));
    end
    if (T_RRD > 1) begin : g_rrd_chk
      // R3
      rrd_gap_chk: assert property (@(posedge clk) disable iff (rst) act_ev |=> !act_ev);
    end
  endgenerate
endmodule

// File: rtl/ddr_bank_guard.sv
module ddr_bank_guard
  import bank_guard_pkg::*;
#(
  parameter int NB        = 4,
  parameter int ROW_W     = 13,
  parameter int BURST_LEN = 4,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 7,
  parameter int T_RC      = 10,
  parameter int T_RRD     = 2,
  parameter int T_WR      = 3,
  parameter int T_MRD     = 2,
  parameter int T_RFC     = 12,
  parameter int T_WTR     = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_valid,
  input  logic [2:0]             cmd_op,
  input  logic [$clog2(NB)-1:0]  cmd_bank,
  input  logic [ROW_W-1:0]       cmd_addr,
  output logic                   cmd_legal,
  output logic                   cmd_error,
  output logic [NB-1:0]          bank_open,
  output logic                   row_hit
);
  localparam int BA_W    = $clog2(NB);
  localparam int AP_BIT  = 10;
  localparam int HALF_BL = BURST_LEN / 2;
  localparam int LIM     = T_RCD + T_RP + T_RAS + T_RC + T_RRD + T_WR + T_MRD
                         + T_RFC + T_WTR + BURST_LEN;
  localparam int CW      = $clog2(LIM + 2);

  logic [NB-1:0]    busy_v, cact_v, ccol_v, cpre_v, idle_v;
  logic [ROW_W-1:0] row_v [NB];
  logic             go, a10, rrd_ok, rd_ok, wr_ok, quiet_ok, pre_all_ok, all_idle;
  logic             is_act, is_col, is_wr, is_pre, is_ref, is_mrs;

  assign a10    = cmd_addr[AP_BIT];
  assign go     = cmd_valid && cmd_legal;
  assign is_act = cmd_op == OP_ACT;
  assign is_wr  = cmd_op == OP_WR;
  assign is_col = (cmd_op == OP_RD) || is_wr;
  assign is_pre = cmd_op == OP_PRE;
  assign is_ref = cmd_op == OP_REF;
  assign is_mrs = cmd_op == OP_MRS;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic sel;
    assign sel = cmd_bank == BA_W'(b);
    bank_tracker #(
      .CW(CW), .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS),
      .T_RC(T_RC), .T_WR(T_WR), .HALF_BL(HALF_BL)
    ) trk_i (
      .clk       (clk),
      .rst       (rst),
      .act_i     (go && is_act && sel),
      .col_i     (go && is_col && sel),
      .col_wr_i  (is_wr),
      .col_ap_i  (a10),
      .pre_i     (go && is_pre && (a10 ? bank_open[b] : sel)),
      .row_i     (cmd_addr),
      .open_o    (bank_open[b]),
      .row_o     (row_v[b]),
      .busy_o    (busy_v[b]),
      .can_act_o (cact_v[b]),
      .can_col_o (ccol_v[b]),
      .can_pre_o (cpre_v[b]),
      .idle_o    (idle_v[b])
    );
  end

  rank_spacing #(
    .CW(CW), .T_RRD(T_RRD), .T_MRD(T_MRD), .T_RFC(T_RFC), .T_WTR(T_WTR), .HALF_BL(HALF_BL)
  ) spc_i (
    .clk      (clk),
    .rst      (rst),
    .act_ev   (go && is_act),
    .col_ev   (go && is_col),
    .col_wr   (is_wr),
    .ref_ev   (go && is_ref),
    .mrs_ev   (go && is_mrs),
    .rrd_ok   (rrd_ok),
    .rd_ok    (rd_ok),
    .wr_ok    (wr_ok),
    .quiet_ok (quiet_ok)
  );

  always_comb begin
    all_idle   = &idle_v;
    pre_all_ok = &(cpre_v | ~bank_open);
    case (cmd_op)
      OP_NOP:  cmd_legal = 1'b1;
      OP_ACT:  cmd_legal = quiet_ok && rrd_ok && cact_v[cmd_bank];
      OP_RD:   cmd_legal = quiet_ok && rd_ok && ccol_v[cmd_bank];
      OP_WR:   cmd_legal = quiet_ok && wr_ok && ccol_v[cmd_bank];
      OP_PRE:  cmd_legal = quiet_ok && (a10 ? pre_all_ok : cpre_v[cmd_bank]);
      OP_REF,
      OP_MRS:  cmd_legal = quiet_ok && all_idle;
      default: cmd_legal = 1'b0;
    endcase
    row_hit = bank_open[cmd_bank] && !busy_v[cmd_bank] && (row_v[cmd_bank] == cmd_addr);
  end

  always_ff @(posedge clk) begin
    if (rst) cmd_error <= 1'b0;
    else     cmd_error <= cmd_valid && (cmd_op != OP_NOP) && !cmd_legal;
  end

  // R6
  pre_all_close_chk: assert property (@(posedge clk) disable iff (rst)
    (go && is_pre && a10) |=> (bank_open == '0));
  // R10
  err_keeps_open_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_legal && is_act) |=> ($past(bank_open[cmd_bank]) || !bank_open[$past(cmd_bank)]));
endmodule

// File: tb/ddr_bank_guard_tb_top.sv
module ddr_bank_guard_tb_top;
  localparam int TRCD = 3, TRP = 3, TRAS = 7, TRC = 10, TRRD = 2, TWR = 3;
  localparam int TMRD = 2, TRFC = 12, TWTR = 1, HALF = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [1:0]  cmd_bank = 2'd0;
  logic [12:0] cmd_addr = '0;
  logic        cmd_legal, cmd_error, row_hit;
  logic [3:0]  bank_open;

  ddr_bank_guard dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .cmd_legal(cmd_legal), .cmd_error(cmd_error),
    .bank_open(bank_open), .row_hit(row_hit)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  // timestamp model
  int          t_act[4], t_close[4], t_rw[4], t_lastact, t_col, t_ref, t_mrs;
  bit          m_open[4], m_ap[4], m_wr[4], col_wr, exp_err;
  logic [12:0] m_row[4];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int rec_need(input int b);
    return m_wr[b] ? HALF + TWR : HALF;
  endfunction

  function automatic bit m_canpre(input int b);
    return m_open[b] && !m_ap[b] && (cyc - t_act[b] >= TRAS) && (cyc - t_rw[b] >= rec_need(b));
  endfunction

  function automatic bit m_idle(input int b);
    return !m_open[b] && (cyc - t_close[b] >= TRP);
  endfunction

  function automatic bit m_legal(input logic [2:0] op, input int b, input logic [12:0] a);
    bit quiet, colok, ok;
    quiet = (cyc - t_ref >= TRFC) && (cyc - t_mrs >= TMRD);
    colok = m_open[b] && !m_ap[b] && (cyc - t_act[b] >= TRCD);
    case (op)
      3'd0: return 1'b1;
      3'd1: return quiet && (cyc - t_lastact >= TRRD) && !m_open[b] &&
                   (cyc - t_close[b] >= TRP) && (cyc - t_act[b] >= TRC);
      3'd2: return quiet && colok && (cyc - t_col >= (col_wr ? HALF + TWTR : HALF));
      3'd3: return quiet && colok && (cyc - t_col >= HALF);
      3'd4: begin
        if (!a[10]) return quiet && m_canpre(b);
        ok = quiet;
        for (int k = 0; k < 4; k++) if (m_open[k] && !m_canpre(k)) ok = 1'b0;
        return ok;
      end
      3'd5, 3'd6: begin
        ok = quiet;
        for (int k = 0; k < 4; k++) if (!m_idle(k)) ok = 1'b0;
        return ok;
      end
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op, input logic a10);
    case (op)
      3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      3'd4: return a10 ? "R6" : "R5";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic m_apply(input bit v, input logic [2:0] op, input int b, input logic [12:0] a,
                         input bit lg);
    for (int k = 0; k < 4; k++)
      if (m_open[k] && m_ap[k] && (cyc - t_rw[k] >= rec_need(k)) && (cyc - t_act[k] >= TRAS)) begin
        m_open[k] = 1'b0; m_ap[k] = 1'b0; t_close[k] = cyc;  // R7
      end
    if (v && lg) begin
      case (op)
        3'd1: begin m_open[b] = 1'b1; m_row[b] = a; t_act[b] = cyc; t_lastact = cyc; end
        3'd2, 3'd3: begin
          t_rw[b] = cyc; m_wr[b] = (op == 3'd3); m_ap[b] = a[10];
          t_col = cyc; col_wr = (op == 3'd3);
        end
        3'd4: for (int k = 0; k < 4; k++)
                if (m_open[k] && (a[10] || k == b)) begin m_open[k] = 1'b0; t_close[k] = cyc; end
        3'd5: t_ref = cyc;
        3'd6: t_mrs = cyc;
        default: ;
      endcase
    end
  endtask

  task automatic do_cycle(input bit v, input logic [2:0] op, input int b, input logic [12:0] a,
                          output bit lg_seen, output bit err_seen, output logic [3:0] open_seen);
    bit lg, hit;
    logic [3:0] mo;
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_bank = b[1:0]; cmd_addr = a;
    #1;
    lg  = m_legal(op, b, a);
    hit = m_open[b] && !m_ap[b] && (m_row[b] == a);
    for (int k = 0; k < 4; k++) mo[k] = m_open[k];
    chk(cmd_legal == lg, tag_of(op, a[10]), cmd_legal, lg);
    chk(row_hit == hit, "R11", row_hit, hit);
    chk(bank_open == mo, "R11", bank_open, mo);
    chk(cmd_error == exp_err, "R10", cmd_error, exp_err);
    lg_seen = cmd_legal; err_seen = cmd_error; open_seen = bank_open;
    @(posedge clk);
    m_apply(v, op, b, a, lg);
    exp_err = v && (op != 3'd0) && !lg;
    cyc++;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit lg, er;
    logic [3:0] op_s;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 4; k++) begin
      t_act[k] = -1000; t_close[k] = -1000; t_rw[k] = -1000;
      m_open[k] = 0; m_ap[k] = 0; m_wr[k] = 0; m_row[k] = '0;
    end
    t_lastact = -1000; t_col = -1000; t_ref = -1000; t_mrs = -1000; col_wr = 0; exp_err = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    do_cycle(0, 3'd1, 2, 13'h0, lg, er, op_s);
    chk(op_s == 4'h0, "R1", op_s, 0);
    chk(er == 1'b0, "R1", er, 0);
    chk(lg == 1'b1, "R1", lg, 1);

    // directed timing walk
    do_cycle(1, 3'd1, 0, 13'h015, lg, er, op_s);              // t0 ACT b0
    do_cycle(0, 3'd1, 1, 13'h022, lg, er, op_s);              // t1
    chk(lg == 0, "R3", lg, 0);                                // tRRD not met
    do_cycle(1, 3'd1, 1, 13'h022, lg, er, op_s);              // t2 ACT b1
    chk(lg == 1, "R3", lg, 1);
    do_cycle(1, 3'd3, 0, 13'h004, lg, er, op_s);              // t3 WR b0
    chk(lg == 1, "R4", lg, 1);                                // tRCD exactly met
    do_cycle(0, 3'd2, 1, 13'h008, lg, er, op_s);              // t4
    chk(lg == 0, "R4", lg, 0);
    do_cycle(0, 3'd2, 1, 13'h008, lg, er, op_s);              // t5 write-to-read
    chk(lg == 0, "R4", lg, 0);
    do_cycle(1, 3'd2, 1, 13'h408, lg, er, op_s);              // t6 RD b1 auto-precharge
    chk(lg == 1, "R4", lg, 1);
    do_cycle(0, 3'd4, 0, 13'h000, lg, er, op_s);              // t7 write recovery
    chk(lg == 0, "R5", lg, 0);
    do_cycle(1, 3'd4, 0, 13'h000, lg, er, op_s);              // t8 PRE b0
    chk(lg == 1, "R5", lg, 1);
    do_cycle(0, 3'd0, 0, 13'h000, lg, er, op_s);              // t9
    chk(op_s[1] == 1'b1, "R7", op_s[1], 1);
    do_cycle(0, 3'd1, 1, 13'h022, lg, er, op_s);              // t10
    chk(op_s[1] == 1'b0, "R7", op_s[1], 0);
    chk(lg == 0, "R7", lg, 0);
    do_cycle(1, 3'd1, 1, 13'h022, lg, er, op_s);              // t11 illegal issue
    do_cycle(0, 3'd0, 0, 13'h000, lg, er, op_s);              // t12
    chk(er == 1'b1, "R10", er, 1);
    chk(op_s == 4'h0, "R10", op_s, 0);
    do_cycle(0, 3'd1, 1, 13'h022, lg, er, op_s);              // t13
    chk(lg == 1, "R7", lg, 1);
    do_cycle(1, 3'd5, 0, 13'h000, lg, er, op_s);              // t14 REF
    chk(lg == 1, "R8", lg, 1);
    for (int i = 0; i < 10; i++) do_cycle(0, 3'd0, 0, 13'h0, lg, er, op_s);
    do_cycle(0, 3'd1, 2, 13'h001, lg, er, op_s);              // REF+11
    chk(lg == 0, "R8", lg, 0);
    do_cycle(0, 3'd1, 2, 13'h001, lg, er, op_s);              // REF+12
    chk(lg == 1, "R8", lg, 1);
    do_cycle(1, 3'd6, 0, 13'h031, lg, er, op_s);              // MRS
    chk(lg == 1, "R9", lg, 1);
    do_cycle(0, 3'd1, 2, 13'h001, lg, er, op_s);
    chk(lg == 0, "R9", lg, 0);
    do_cycle(0, 3'd1, 2, 13'h001, lg, er, op_s);
    chk(lg == 1, "R9", lg, 1);
    do_cycle(1, 3'd7, 0, 13'h000, lg, er, op_s);
    chk(lg == 0, "R2", lg, 0);
    do_cycle(0, 3'd0, 3, 13'h000, lg, er, op_s);
    chk(lg == 1, "R2", lg, 1);
    chk(er == 1, "R10", er, 1);
    do_cycle(1, 3'd4, 0, 13'h400, lg, er, op_s);              // precharge-all, nothing open
    chk(lg == 1, "R6", lg, 1);

    // constrained random traffic
    for (int i = 0; i < 6000; i++) begin
      int unsigned r, pick;
      logic [2:0]  op;
      logic [12:0] a;
      int          b;
      bit          v;
      r = $urandom;
      pick = r % 32;
      if (pick < 8)       op = 3'd1;
      else if (pick < 13) op = 3'd2;
      else if (pick < 18) op = 3'd3;
      else if (pick < 25) op = 3'd4;
      else if (pick == 25) op = 3'd5;
      else if (pick == 26) op = 3'd6;
      else if (pick == 27) op = 3'd7;
      else op = 3'd0;
      b = int'(($urandom >> 3) % 4);
      a = 13'(($urandom >> 5) % 4);
      if ((($urandom >> 9) % 4) == 0) a[10] = 1'b1;
      if (m_legal(op, b, a)) v = (($urandom >> 12) % 10) != 0;
      else                   v = (($urandom >> 12) % 12) == 0;
      do_cycle(v, op, b, a, lg, er, op_s);
    end
    do_cycle(0, 3'd0, 0, 13'h0, lg, er, op_s);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule